// File: doc/BRIEF.md
# Dithered Green-Mode Switching Oscillator

This block issues the start-of-cycle ticks for a current-mode flyback controller. In normal operation the switching period wobbles slowly around a centre value: a triangular sweep moves it one step per switching cycle between a shortest and a longest period. This spreads the conducted and radiated noise over a band instead of one line. All periods are whole counts of the system clock, derived at elaboration from the clock rate and the target frequencies, each rounded to the nearest count.

Two comparator flags taken from the feedback voltage select the operating mode. A light-load flag stretches the next cycle to a fixed long period. A very-low-feedback flag stops switching at once. Switching restarts on its own as soon as that flag clears, with no latching. An enable input from the protection logic has the same effect as the stop flag. The block reports the period of the cycle in progress and a two-bit mode code.

Top module: `green_osc`

## Requirements
- R1: While reset is asserted, `strobe_o` is 0, `mode_o` is 2 (off) and `period_o` is the centre period. Reset also returns the sweep to the centre period, rising first. The first strobe comes one clock after reset is released, provided the block is enabled and the stop flag is low.
- R2: While the block runs, `strobe_o` is high for exactly one clock. Consecutive strobes are exactly `period_o` clocks apart, where `period_o` is the value shown during the earlier strobe.
- R3: Each period is round(CLK_HZ / f): centre f = CENTER_HZ, shortest f = CENTER_HZ + SPREAD_HZ/2, longest f = CENTER_HZ - SPREAD_HZ/2. Normal cycles (`mode_o` = 0) use a triangle sequence. It starts at the centre and rises first, changes by DITHER_STEP per normal cycle, and includes both end values, reversing direction at each.
- R4: If `green_i` is high at a cycle start, that cycle uses the green period round(CLK_HZ / GREEN_HZ) and `mode_o` = 1. The sweep position does not move during green cycles.
- R5: While `off_i` is high, no strobe is issued from the next clock on, `mode_o` reads 2 from the next clock, and the running cycle is abandoned.
- R6: When `off_i` falls with `en_i` high, a strobe follows on the next clock. No latched state is left behind.
- R7: A change of `green_i` in the middle of a cycle changes neither that cycle's length nor `mode_o` until the next strobe.
- R8: While `en_i` is low, the counter is held cleared, no strobe is issued and `mode_o` reads 2. A strobe follows one clock after `en_i` returns high.
- R9: `period_o` changes only on a strobe clock. While the block was running on the previous clock, `mode_o` also changes only on a strobe clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run permission from the protection logic |
| green_i | input | 1 | Feedback below the light-load threshold |
| off_i | input | 1 | Feedback below the stop threshold |
| strobe_o | output | 1 | One-clock pulse at each switching-cycle start |
| period_o | output | PW | Length in clocks of the cycle in progress |
| mode_o | output | 2 | 0 normal, 1 green, 2 off |

## Verification
The bench builds the block with a 1 MHz clock parameter, a 100 kHz centre, a 20 kHz spread and a 25 kHz green frequency. This gives normal periods of 9, 10 and 11 clocks and a green period of 40. A full sweep turn therefore takes only four normal cycles, so both turnarounds can be reached quickly. Green cycles inserted mid-sweep show that the sweep position is held. The short cycles also leave room to place stop, disable and reset events at chosen points inside a cycle.

// File: rtl/osc_pkg.sv
package osc_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_GREEN  = 2'd1,
      MODE_OFF    = 2'd2
   } osc_mode_e;

   // nearest-integer division, used for every period derivation
   function automatic int unsigned div_round(input int unsigned num, input int unsigned den);
      return (num + den / 2) / den;
   endfunction

endpackage

// File: rtl/osc_cycle_cnt.sv
// Cycle counter: cleared while not running, marks the cycle boundary and
// registers the start strobe.
module osc_cycle_cnt #(
   parameter int PW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [PW-1:0] period_i,
   output logic          boundary,
   output logic          strobe_q
);

   logic [PW-1:0] cnt_q;

   assign boundary = run && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= boundary;
         if (!run) begin
            cnt_q <= '0;
         end else if (cnt_q == '0) begin
            cnt_q <= {{(PW-1){1'b0}}, 1'b1};
         end else if (cnt_q >= period_i - 1'b1) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/osc_dither.sv
// Triangular sweep of the normal period, one step per advance pulse.
module osc_dither #(
   parameter int PW    = 9,
   parameter int NOM_P = 154,
   parameter int MIN_P = 149,
   parameter int MAX_P = 159,
   parameter int STEP  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [PW-1:0] per_o
);

   localparam logic [PW:0] MAX_X     = (PW+1)'(MAX_P);
   localparam logic [PW:0] MIN_X     = (PW+1)'(MIN_P);
   localparam logic [PW:0] STEP_X    = (PW+1)'(STEP);
   localparam logic [PW:0] LOW_TURN  = (PW+1)'(MIN_P + STEP);

   logic [PW-1:0] pos_q;
   logic          rising_q;
   logic [PW:0]   pos_x;
   logic [PW:0]   up_x;
   logic [PW:0]   dn_x;

   assign pos_x = {1'b0, pos_q};
   assign up_x  = pos_x + STEP_X;
   assign dn_x  = pos_x - STEP_X;
   assign per_o = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= PW'(NOM_P);
         rising_q <= 1'b1;
      end else if (adv) begin
         if (rising_q) begin
            if (up_x >= MAX_X) begin
               pos_q    <= MAX_X[PW-1:0];
               rising_q <= 1'b0;
            end else begin
               pos_q <= up_x[PW-1:0];
            end
         end else begin
            if (pos_x <= LOW_TURN) begin
               pos_q    <= MIN_X[PW-1:0];
               rising_q <= 1'b1;
            end else begin
               pos_q <= dn_x[PW-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/osc_mode_sel.sv
// Latches the period and mode of each cycle at its boundary.
module osc_mode_sel #(
   parameter int PW      = 9,
   parameter int NOM_P   = 154,
   parameter int GREEN_P = 500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             boundary,
   input  logic             green_i,
   input  logic [PW-1:0]    dith_i,
   output logic [PW-1:0]    period_q,
   output osc_pkg::osc_mode_e mode_q
);
   import osc_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= PW'(NOM_P);
         mode_q   <= MODE_OFF;
      end else if (!run) begin
         mode_q <= MODE_OFF;
      end else if (boundary) begin
         if (green_i) begin
            period_q <= PW'(GREEN_P);
            mode_q   <= MODE_GREEN;
         end else begin
            period_q <= dith_i;
            mode_q   <= MODE_NORMAL;
         end
      end
   end

endmodule

// File: rtl/green_osc.sv
// Dithered green-mode switching oscillator, top level.
module green_osc #(
   parameter int CLK_HZ      = 10_000_000,
   parameter int CENTER_HZ   = 65_000,
   parameter int SPREAD_HZ   = 4_000,
   parameter int GREEN_HZ    = 20_000,
   parameter int DITHER_STEP = 1,
   parameter bit DITHER_EN   = 1'b1,
   parameter int PW          = $clog2(osc_pkg::div_round(CLK_HZ, GREEN_HZ) + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          green_i,
   input  logic          off_i,
   output logic          strobe_o,
   output logic [PW-1:0] period_o,
   output logic [1:0]    mode_o
);
   import osc_pkg::*;

   localparam int NOM_P   = int'(div_round(CLK_HZ, CENTER_HZ));
   localparam int MIN_P   = int'(div_round(CLK_HZ, CENTER_HZ + SPREAD_HZ / 2));
   localparam int MAX_P   = int'(div_round(CLK_HZ, CENTER_HZ - SPREAD_HZ / 2));
   localparam int GREEN_P = int'(div_round(CLK_HZ, GREEN_HZ));

   // elaboration-time parameter checks
   if (MIN_P < 2) begin : g_err_min
      $error("shortest period must be at least two clocks");
   end
   if (GREEN_P <= MAX_P) begin : g_err_green
      $error("green period must exceed the longest normal period");
   end
   if (DITHER_STEP < 1) begin : g_err_step
      $error("dither step must be positive");
   end
   if ((1 << PW) <= GREEN_P) begin : g_err_pw
      $error("period width too narrow for the green period");
   end
   if (SPREAD_HZ >= CENTER_HZ) begin : g_err_spread
      $error("spread must be below the centre frequency");
   end

   logic          run;
   logic          boundary;
   logic [PW-1:0] dith_per;
   osc_mode_e     mode_q;

   assign run = en_i && !off_i;

   osc_cycle_cnt #(.PW(PW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .period_i (period_o),
      .boundary (boundary),
      .strobe_q (strobe_o)
   );

   if (DITHER_EN) begin : g_dither
      osc_dither #(
         .PW    (PW),
         .NOM_P (NOM_P),
         .MIN_P (MIN_P),
         .MAX_P (MAX_P),
         .STEP  (DITHER_STEP)
      ) u_dith (
         .clk   (clk),
         .rst_n (rst_n),
         .adv   (boundary && !green_i),
         .per_o (dith_per)
      );
   end else begin : g_fixed
      assign dith_per = PW'(NOM_P);
   end

   osc_mode_sel #(
      .PW      (PW),
      .NOM_P   (NOM_P),
      .GREEN_P (GREEN_P)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .boundary (boundary),
      .green_i  (green_i),
      .dith_i   (dith_per),
      .period_q (period_o),
      .mode_q   (mode_q)
   );

   assign mode_o = mode_q;

endmodule

// File: rtl/osc_checker.sv
// Protocol checker bound to the oscillator top.
module osc_checker #(
   parameter int PW      = 9,
   parameter int MIN_P   = 149,
   parameter int MAX_P   = 159,
   parameter int GREEN_P = 500
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en_i,
   input logic          off_i,
   input logic          strobe_o,
   input logic [PW-1:0] period_o,
   input logic [1:0]    mode_o
);

   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);

   assert_normal_in_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_o && mode_o == 2'd0) |-> (period_o >= PW'(MIN_P) && period_o <= PW'(MAX_P)));

   assert_green_pairing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> ((mode_o == 2'd1) == (period_o == PW'(GREEN_P))));

   assert_stop_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      off_i |=> (!strobe_o && mode_o == 2'd2));

   assert_resume_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!en_i || off_i) && en_i && !off_i) |=> strobe_o);

   assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!strobe_o && mode_o == 2'd2));

   assert_period_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_o |-> $stable(period_o));

   assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_o && $past(en_i && !off_i)) |-> $stable(mode_o));

   assert_mode_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o != 2'd3);

endmodule

bind green_osc osc_checker #(
   .PW      (PW),
   .MIN_P   (MIN_P),
   .MAX_P   (MAX_P),
   .GREEN_P (GREEN_P)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_i     (en_i),
   .off_i    (off_i),
   .strobe_o (strobe_o),
   .period_o (period_o),
   .mode_o   (mode_o)
);

// File: tb/sim_green_osc.sv
module sim_green_osc;

   localparam int CLK_PERIOD_NS = 10;
   localparam int PW            = 6;
   localparam int GREEN_P       = 40;

   // vector: [8] green flag, [7:2] expected period, [1:0] expected mode
   localparam int NVEC = 10;
   localparam logic [8:0] VEC [NVEC] = '{
      {1'b0, 6'd10, 2'd0},
      {1'b0, 6'd11, 2'd0},
      {1'b1, 6'd40, 2'd1},
      {1'b1, 6'd40, 2'd1},
      {1'b0, 6'd10, 2'd0},
      {1'b0, 6'd9,  2'd0},
      {1'b0, 6'd10, 2'd0},
      {1'b1, 6'd40, 2'd1},
      {1'b0, 6'd11, 2'd0},
      {1'b0, 6'd10, 2'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 1'b1;
   logic green_i = 1'b0;
   logic off_i = 1'b0;
   wire          strobe_o;
   wire [PW-1:0] period_o;
   wire [1:0]    mode_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD_NS / 2) clk = ~clk;

   green_osc #(
      .CLK_HZ      (1_000_000),
      .CENTER_HZ   (100_000),
      .SPREAD_HZ   (20_000),
      .GREEN_HZ    (25_000),
      .DITHER_STEP (1),
      .DITHER_EN   (1'b1),
      .PW          (PW)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .green_i  (green_i),
      .off_i    (off_i),
      .strobe_o (strobe_o),
      .period_o (period_o),
      .mode_o   (mode_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_strobe(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!strobe_o && n < 1000);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD_NS * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int n;
      int prev_p;
      int quiet;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(strobe_o == 1'b0, "R1 strobe in reset", strobe_o, 0);
      check(mode_o == 2'd2, "R1 mode in reset", mode_o, 2);
      check(period_o == 10, "R1 period in reset", period_o, 10);
      rst_n = 1'b1;

      // table walk: sweep and green insertion (R2, R3, R4)
      prev_p = 0;
      for (int i = 0; i < NVEC; i++) begin
         green_i = VEC[i][8];
         wait_strobe(n);
         if (i == 0) check(n == 1, "R1 first strobe", n, 1);
         else check(n == prev_p, "R2 strobe spacing", n, prev_p);
         check(period_o == VEC[i][7:2], VEC[i][8] ? "R4 green period" : "R3 sweep period",
               period_o, VEC[i][7:2]);
         check(mode_o == VEC[i][1:0], VEC[i][8] ? "R4 green mode" : "R3 normal mode",
               mode_o, VEC[i][1:0]);
         prev_p = VEC[i][7:2];
      end

      // R7: green raised mid-cycle takes effect at the next start only
      @(negedge clk);
      green_i = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(mode_o == 2'd0, "R7 mode held mid-cycle", mode_o, 0);
      end
      wait_strobe(n);
      check(n + 4 == 10, "R7 cycle length kept", n + 4, 10);
      check(mode_o == 2'd1 && period_o == GREEN_P, "R7 green at boundary", period_o, GREEN_P);
      green_i = 1'b0;
      wait_strobe(n);
      check(n == GREEN_P, "R4 green spacing", n, GREEN_P);
      check(period_o == 9, "R4 sweep held during green", period_o, 9);

      // R5/R6: stop flag mid-cycle, then release
      repeat (2) @(negedge clk);
      off_i = 1'b1;
      @(negedge clk);
      check(mode_o == 2'd2, "R5 mode off", mode_o, 2);
      quiet = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (strobe_o) quiet++;
      end
      check(quiet == 0, "R5 no strobe while stopped", quiet, 0);
      off_i = 1'b0;
      @(negedge clk);
      check(strobe_o == 1'b1, "R6 resume strobe", strobe_o, 1);
      check(mode_o == 2'd0 && period_o == 10, "R6 resume period", period_o, 10);

      // R8: enable low, then back with green requested
      repeat (4) @(negedge clk);
      en_i = 1'b0;
      @(negedge clk);
      check(mode_o == 2'd2, "R8 mode off when disabled", mode_o, 2);
      quiet = 0;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (strobe_o) quiet++;
      end
      check(quiet == 0, "R8 no strobe when disabled", quiet, 0);
      green_i = 1'b1;
      en_i = 1'b1;
      @(negedge clk);
      check(strobe_o == 1'b1, "R8 strobe after enable", strobe_o, 1);
      check(mode_o == 2'd1 && period_o == GREEN_P, "R8 green after enable", period_o, GREEN_P);

      // R5: stop during a green cycle, resume in normal mode
      repeat (5) @(negedge clk);
      off_i = 1'b1;
      green_i = 1'b0;
      @(negedge clk);
      check(strobe_o == 1'b0 && mode_o == 2'd2, "R5 stop during green", mode_o, 2);
      off_i = 1'b0;
      @(negedge clk);
      check(strobe_o == 1'b1, "R6 resume after green stop", strobe_o, 1);
      check(mode_o == 2'd0 && period_o == 11, "R3 sweep upper end", period_o, 11);

      // R1: reset mid-run restores the sweep to the centre
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(strobe_o == 1'b0 && mode_o == 2'd2, "R1 mode after mid-run reset", mode_o, 2);
      check(period_o == 10, "R1 period after mid-run reset", period_o, 10);
      rst_n = 1'b1;
      @(negedge clk);
      check(strobe_o == 1'b1 && period_o == 10, "R1 restart at centre", period_o, 10);
      wait_strobe(n);
      check(n == 10, "R2 spacing after restart", n, 10);
      check(period_o == 11, "R3 sweep rises first", period_o, 11);

      finish_run();
   end

endmodule